// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Unit

The unit snoops inbound memory writes. A write whose address equals a programmed 64-bit target base is taken as a message-signalled interrupt, and its data word is the vector number, from 0 to 63. That vector sets one pending bit. The pending bits sit in two 32-bit status words. Each word has its own enable mask and drives its own interrupt line. One word holds vectors 0 to 31 and the other holds vectors 32 to 63.

Software uses a simple register port to set the target base, the two enable bits in the control word and the masks. It also reads the pending words and clears them by writing ones. Reads are combinational from the register address. An inbound write updates the status on the clock edge where it is presented.

Register map (byte offsets on `reg_addr_i`): capability 0x400, control 0x404, base low 0x408, base high 0x40C, low status 0x440, high status 0x444, low mask 0x448, high mask 0x44C.

Top module: `msi_capture_unit`

## Requirements
- R1: After reset every pending bit, mask bit, base bit and control bit is 0, and both interrupt outputs are low.
- R2: With capture enabled, a write to the exact base address with data v < 32 sets low-status bit v. With 32 ≤ v < 64 it sets high-status bit v−32. Each such write sets at most one bit.
- R3: A write to any address other than the 64-bit base {base high, base low} sets no bit.
- R4: A matching write whose data is 64 or larger sets no bit.
- R5: A status bit is set only while both control bits are 1: bit 0 (capture enable) and bit 15 (status-update enable). If either is 0, no bit is set.
- R6: Writing a word to a status offset clears each bit written as 1 and leaves bits written as 0 unchanged. One bit or several bits may be cleared in a single write.
- R7: If a capture and a clear hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq_lo_o` is high exactly when some low-status bit is set and its low-mask bit is 1. `irq_hi_o` behaves the same way for the high word. A mask bit of 0 blocks its vector from the line.
- R9: The capability word always reads 1 in bit 0 (capture present) and 0 elsewhere. Writes to it are ignored.
- R10: The base, mask and control words read back the values last written. Only control bits 0 and 15 are stored, and the other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Inbound write strobe |
| wr_addr_i | input | 64 | Inbound write address |
| wr_data_i | input | 32 | Inbound write data (vector number) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_lo_o | output | 1 | Interrupt for vectors 0 to 31 |
| irq_hi_o | output | 1 | Interrupt for vectors 32 to 63 |

## Verification
An inbound write or a register write presented before a rising edge takes effect on that edge. The status readback and both interrupt lines reflect it right after that edge, one register stage and no more. The bench drives stimulus at the falling edge and holds it across one rising edge. It then drives the read address at the next falling edge and queues the expected read value and line levels. The monitor compares them 2 ns after the following rising edge, when no input is active. This keeps every sample one full register stage after its stimulus.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int BANK_W    = 32;
  localparam int NUM_BANKS = 2;
  localparam int NUM_VEC   = BANK_W * NUM_BANKS;
  localparam int REG_AW    = 12;
  localparam int IN_AW     = 64;
  localparam int DW        = 32;

  localparam logic [REG_AW-1:0] OFS_CAP     = 12'h400;
  localparam logic [REG_AW-1:0] OFS_CTRL    = 12'h404;
  localparam logic [REG_AW-1:0] OFS_BASE_LO = 12'h408;
  localparam logic [REG_AW-1:0] OFS_BASE_HI = 12'h40C;
  localparam logic [REG_AW-1:0] OFS_STAT0   = 12'h440;
  localparam logic [REG_AW-1:0] OFS_MASK0   = 12'h448;

  localparam int CTRL_CAP_BIT = 0;
  localparam int CTRL_UPD_BIT = 15;
endpackage

// File: rtl/msi_match.sv
module msi_match #(
  parameter int IN_AW = msi_cap_pkg::IN_AW,
  parameter int DW    = msi_cap_pkg::DW,
  parameter int NV    = msi_cap_pkg::NUM_VEC
) (
  input  logic             wr_valid_i,
  input  logic [IN_AW-1:0] wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [IN_AW-1:0] base_i,
  input  logic             capture_en_i,
  output logic [NV-1:0]    set_o
);
  localparam int IDX_W = $clog2(NV);

  logic hit;

  always_comb begin
    hit   = wr_valid_i && capture_en_i && (wr_addr_i == base_i) &&
            (wr_data_i < DW'(NV));
    set_o = '0;
    if (hit) set_o[wr_data_i[IDX_W-1:0]] = 1'b1;
  end
endmodule

// File: rtl/msi_bank.sv
module msi_bank #(
  parameter int W = msi_cap_pkg::BANK_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] stat_q, mask_q, clr_bits;

  assign clr_bits = clr_we_i ? wdata_i : '0;

  // set after clear: capture wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_bits) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= wdata_i;
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & mask_q);

  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_bits & ~set_i) != '0 |=> (stat_q & $past(clr_bits & ~set_i)) == '0); // R6
  AST_CAPTURE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i & clr_bits) != '0 |=> (stat_q & $past(set_i)) == $past(set_i)); // R7
  AST_NO_SELF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stat_q & ~$past(stat_q) & ~$past(set_i)) == '0); // R2
  AST_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q == '0 |-> !irq_o); // R8
endmodule

// File: rtl/msi_regs.sv
module msi_regs #(
  parameter int AW    = msi_cap_pkg::REG_AW,
  parameter int DW    = msi_cap_pkg::DW,
  parameter int IN_AW = msi_cap_pkg::IN_AW,
  parameter int NB    = msi_cap_pkg::NUM_BANKS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  input  logic [NB*DW-1:0] stat_i,
  input  logic [NB*DW-1:0] mask_i,
  output logic [IN_AW-1:0] base_o,
  output logic             capture_en_o,
  output logic [NB-1:0]    clr_we_o,
  output logic [NB-1:0]    mask_we_o,
  output logic [DW-1:0]    rdata_o
);
  import msi_cap_pkg::*;

  logic          cap_en_q, upd_en_q;
  logic [DW-1:0] base_lo_q, base_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_en_q  <= 1'b0;
      upd_en_q  <= 1'b0;
      base_lo_q <= '0;
      base_hi_q <= '0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == OFS_CTRL) begin
        cap_en_q <= reg_wdata_i[CTRL_CAP_BIT];
        upd_en_q <= reg_wdata_i[CTRL_UPD_BIT];
      end
      if (reg_addr_i == OFS_BASE_LO) base_lo_q <= reg_wdata_i;
      if (reg_addr_i == OFS_BASE_HI) base_hi_q <= reg_wdata_i;
    end
  end

  assign base_o       = IN_AW'({base_hi_q, base_lo_q});
  assign capture_en_o = cap_en_q & upd_en_q;

  for (genvar b = 0; b < NB; b++) begin : g_strobe
    assign clr_we_o[b]  = reg_wr_i && (reg_addr_i == OFS_STAT0 + AW'(4*b));
    assign mask_we_o[b] = reg_wr_i && (reg_addr_i == OFS_MASK0 + AW'(4*b));
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_i)
      OFS_CAP:     rdata_o = DW'(1);
      OFS_CTRL: begin
        rdata_o[CTRL_CAP_BIT] = cap_en_q;
        rdata_o[CTRL_UPD_BIT] = upd_en_q;
      end
      OFS_BASE_LO: rdata_o = base_lo_q;
      OFS_BASE_HI: rdata_o = base_hi_q;
      default: begin
        for (int b = 0; b < NB; b++) begin
          if (reg_addr_i == OFS_STAT0 + AW'(4*b)) rdata_o = stat_i[b*DW +: DW];
          if (reg_addr_i == OFS_MASK0 + AW'(4*b)) rdata_o = mask_i[b*DW +: DW];
        end
      end
    endcase
  end

  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == OFS_CTRL |=>
      capture_en_o == ($past(reg_wdata_i[CTRL_CAP_BIT]) && $past(reg_wdata_i[CTRL_UPD_BIT]))); // R10
endmodule

// File: rtl/msi_capture_unit.sv
module msi_capture_unit #(
  parameter int IN_AW = msi_cap_pkg::IN_AW,
  parameter int DW    = msi_cap_pkg::DW,
  parameter int AW    = msi_cap_pkg::REG_AW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [IN_AW-1:0] wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             reg_wr_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_lo_o,
  output logic             irq_hi_o
);
  import msi_cap_pkg::*;
  localparam int NB = NUM_BANKS;
  localparam int BW = BANK_W;
  localparam int NV = NB * BW;

  logic [IN_AW-1:0] base;
  logic             capture_en;
  logic [NB-1:0]    clr_we, mask_we, irq;
  logic [NV-1:0]    set_vec, stat_all, mask_all;

  msi_regs #(.AW(AW), .DW(DW), .IN_AW(IN_AW), .NB(NB)) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i,
    .stat_i(stat_all), .mask_i(mask_all),
    .base_o(base), .capture_en_o(capture_en),
    .clr_we_o(clr_we), .mask_we_o(mask_we), .rdata_o(reg_rdata_o)
  );

  msi_match #(.IN_AW(IN_AW), .DW(DW), .NV(NV)) u_match (
    .wr_valid_i, .wr_addr_i, .wr_data_i,
    .base_i(base), .capture_en_i(capture_en), .set_o(set_vec)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    msi_bank #(.W(BW)) u_bank (
      .clk_i, .rst_ni,
      .set_i(set_vec[b*BW +: BW]),
      .clr_we_i(clr_we[b]),
      .mask_we_i(mask_we[b]),
      .wdata_i(reg_wdata_i[BW-1:0]),
      .stat_o(stat_all[b*BW +: BW]),
      .mask_o(mask_all[b*BW +: BW]),
      .irq_o(irq[b])
    );
  end

  assign irq_lo_o = irq[0];
  assign irq_hi_o = irq[1];

  AST_DISABLED_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_en |=> (stat_all & ~$past(stat_all)) == '0); // R5
  AST_ONE_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(stat_all & ~$past(stat_all)) <= 1); // R2
  AST_MISMATCH_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_addr_i != base && !(reg_wr_i && reg_addr_i == OFS_BASE_LO) |=>
      (stat_all & ~$past(stat_all)) == '0); // R3
endmodule

// File: tb/msi_capture_unit_tb.sv
module msi_capture_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [63:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_lo, irq_hi;

  always #5 clk = ~clk;

  msi_capture_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  localparam logic [11:0] A_CAP = 12'h400, A_CTRL = 12'h404, A_BLO = 12'h408,
                          A_BHI = 12'h40C, A_SLO = 12'h440, A_SHI = 12'h444,
                          A_MLO = 12'h448, A_MHI = 12'h44C;

  // reference model
  logic [63:0] m_stat = '0;
  logic [31:0] m_mlo = '0, m_mhi = '0, m_blo = '0, m_bhi = '0;
  logic        m_cap = 1'b0, m_upd = 1'b0;

  typedef struct {
    logic [31:0] rd;
    logic        lo;
    logic        hi;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  int checks = 0, errors = 0;
  bit done = 1'b0;

  function automatic logic [31:0] model_read(logic [11:0] a);
    case (a)
      A_CAP:  return 32'h1;
      A_CTRL: return {16'h0, m_upd, 14'h0, m_cap};
      A_BLO:  return m_blo;
      A_BHI:  return m_bhi;
      A_SLO:  return m_stat[31:0];
      A_SHI:  return m_stat[63:32];
      A_MLO:  return m_mlo;
      A_MHI:  return m_mhi;
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_capture(logic [63:0] a, logic [31:0] d);
    if (m_cap && m_upd && a == {m_bhi, m_blo} && d < 32'd64) m_stat[d[5:0]] = 1'b1;
  endfunction

  function automatic void model_reg(logic [11:0] a, logic [31:0] d);
    case (a)
      A_CTRL: begin m_cap = d[0]; m_upd = d[15]; end
      A_BLO:  m_blo = d;
      A_BHI:  m_bhi = d;
      A_SLO:  m_stat[31:0]  = m_stat[31:0]  & ~d;
      A_SHI:  m_stat[63:32] = m_stat[63:32] & ~d;
      A_MLO:  m_mlo = d;
      A_MHI:  m_mhi = d;
      default: ;
    endcase
  endfunction

  task automatic idle_inputs();
    wr_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic reg_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    model_reg(a, d);
    idle_inputs();
  endtask

  task automatic msi_write(logic [63:0] a, logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    model_capture(a, d);
    idle_inputs();
  endtask

  // capture and status clear in the same cycle
  task automatic msi_and_clear(logic [63:0] a, logic [31:0] d,
                               logic [11:0] ca, logic [31:0] cd);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    reg_wr = 1'b1; reg_addr = ca; reg_wdata = cd;
    @(posedge clk); #1;
    model_reg(ca, cd);
    model_capture(a, d);
    idle_inputs();
  endtask

  // driver: queue the expected item, monitor compares after the next edge
  task automatic check(logic [11:0] a, string tag);
    exp_t e;
    @(negedge clk);
    reg_addr = a;
    e.rd  = model_read(a);
    e.lo  = |(m_stat[31:0]  & m_mlo);
    e.hi  = |(m_stat[63:32] & m_mhi);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #2;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (reg_rdata !== e.rd || irq_lo !== e.lo || irq_hi !== e.hi) begin
          errors++;
          $display("FAIL %s: got rdata=%h lo=%b hi=%b, expected rdata=%h lo=%b hi=%b",
                   e.tag, reg_rdata, irq_lo, irq_hi, e.rd, e.lo, e.hi);
        end
      end
    end
  end

  // watchdog
  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [63:0] BASE = 64'h0000_00F0_FEE0_1000;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check(A_SLO, "R1 low status");
    check(A_SHI, "R1 high status");
    check(A_MLO, "R1 low mask");
    check(A_CTRL, "R1 control");
    check(A_BHI, "R1 base high");

    // R9 capability read-only
    check(A_CAP, "R9 capability");
    reg_write(A_CAP, 32'h0);
    check(A_CAP, "R9 capability after write");

    // R10 readback
    reg_write(A_CTRL, 32'hFFFF_FFFF);
    check(A_CTRL, "R10 control only bits 0 and 15");
    reg_write(A_CTRL, 32'h0);
    reg_write(A_BLO, BASE[31:0]);
    reg_write(A_BHI, BASE[63:32]);
    check(A_BLO, "R10 base low");
    check(A_BHI, "R10 base high");
    reg_write(A_MLO, 32'hFFFF_FFFF);
    reg_write(A_MHI, 32'hFFFF_FFFF);
    check(A_MHI, "R10 high mask");

    // R5 enables
    reg_write(A_CTRL, 32'h0000_0001);
    msi_write(BASE, 32'd3);
    check(A_SLO, "R5 update enable clear");
    reg_write(A_CTRL, 32'h0000_8000);
    msi_write(BASE, 32'd3);
    check(A_SLO, "R5 capture enable clear");
    reg_write(A_CTRL, 32'h0000_8001);

    // R2 vector decode
    msi_write(BASE, 32'd0);
    check(A_SLO, "R2 vector 0");
    msi_write(BASE, 32'd31);
    check(A_SLO, "R2 vector 31");
    msi_write(BASE, 32'd32);
    check(A_SHI, "R2 vector 32");
    msi_write(BASE, 32'd63);
    check(A_SHI, "R2 vector 63");
    msi_write(BASE, 32'd5);
    check(A_SLO, "R2 vector 5");

    // R3 address mismatch
    msi_write(BASE ^ 64'h1, 32'd7);
    msi_write(BASE ^ (64'h1 << 40), 32'd7);
    check(A_SLO, "R3 mismatched address");

    // R4 data out of range
    msi_write(BASE, 32'd64);
    msi_write(BASE, 32'h8000_0001);
    check(A_SLO, "R4 data above range low");
    check(A_SHI, "R4 data above range high");

    // R6 write-one-to-clear
    reg_write(A_SLO, 32'h0000_0001);
    check(A_SLO, "R6 single clear");
    reg_write(A_SLO, 32'h8000_0020);
    check(A_SLO, "R6 multiple clear");
    reg_write(A_SHI, 32'h0000_0000);
    check(A_SHI, "R6 zero write keeps bits");

    // R8 masking
    reg_write(A_SHI, 32'hFFFF_FFFF);
    reg_write(A_MLO, 32'h0);
    msi_write(BASE, 32'd9);
    check(A_SLO, "R8 low masked off");
    reg_write(A_MLO, 32'h0000_0200);
    check(A_MLO, "R8 low mask enables vector 9");
    msi_write(BASE, 32'd40);
    reg_write(A_MHI, 32'h0000_0001);
    check(A_SHI, "R8 high mask blocks vector 40");
    reg_write(A_MHI, 32'h0000_0100);
    check(A_SHI, "R8 high mask passes vector 40");

    // R7 capture wins over clear
    msi_and_clear(BASE, 32'd9, A_SLO, 32'h0000_0200);
    check(A_SLO, "R7 same-bit capture wins");
    msi_write(BASE, 32'd12);
    msi_and_clear(BASE, 32'd44, A_SLO, 32'h0000_1200);
    check(A_SLO, "R7 clear of other word");
    check(A_SHI, "R7 capture into other word");

    @(posedge clk); #5;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule